// File: doc/BRIEF.md
# Level Interrupt Router for Two Cores

This block collects up to 32 level-sensitive, active-high interrupt sources and steers each one to four outputs. There is a normal interrupt line for each of two processor cores, and a machine-check line for each of the same two cores. Every input first passes through a two-flop synchronizer. The synchronized levels form a live status word. Each output is a registered OR of the status bits that its own enable mask lets through.

The block keeps no latched or pending state and has no acknowledge path, so an output follows its unmasked live levels. Software finds out which source is active, and picks which one to serve first, by reading the status and mask registers over a simple 32-bit register bus with read and write strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `lvl_irq_router`

## Requirements
- R1: Reading offset 0x00 returns the synchronized input levels, with bit n equal to src_i[n]. A level that is stable for two clock edges is visible to a read issued after those edges.
- R2: Status bits 6 and 17 to 31 are reserved. They always read as zero and never drive any output.
- R3: The four mask registers are read/write. The core 0 and core 1 interrupt masks sit at 0x10 and 0x14. The core 0 and core 1 machine-check masks sit at 0x18 and 0x1C. In each mask, bit n = 1 enables source n and 0 blocks it.
- R4: irq_o[c] is high in the cycle after the OR of (status AND core c interrupt mask) is nonzero, and low in the cycle after it is zero.
- R5: mcheck_o[c] follows the core c machine-check mask in the same way as R4.
- R6: A source enabled in more than one mask asserts every one of those outputs in the same cycle, with no arbitration between them.
- R7: There is no acknowledge. An asserted output stays high, even across register reads, until its source falls or its mask bit is cleared.
- R8: After reset, all masks are zero, all outputs are low and rdata_o is zero.
- R9: Writes to 0x00 or to any unmapped offset change no register. Reads of unmapped offsets return zero.
- R10: rdata_o updates only on a clock edge where rd_en_i is high. It holds its value otherwise.
- R11: A change on an enabled input reaches its output on the third rising edge after the change: two synchronizer stages and then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt sources, active high |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 2 | Interrupt line per core |
| mcheck_o | output | 2 | Machine-check line per core |

## Verification
If a mask register is written or decoded wrongly, the fault shows up one cycle later. Either the wrong output line rises or falls, or the register reads back a value that differs from what was written. A fault in a synchronizer stage shifts the input-to-output latency away from three edges, and the bench catches that at the exact cycle. A reserved bit or a write to the status offset that leaks through shows up on the next read of the affected register, or as an output that rises when it should stay low.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int unsigned NUM_SRC   = 32;
  localparam int unsigned NUM_CORES = 2;
  localparam int unsigned ADDR_W    = 8;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IRQ_MSK = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MC_MSK  = 8'h18;
  localparam logic [NUM_SRC-1:0] RSVD_BITS  = 32'hFFFE_0040;
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RSVD  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] status_o
);
  logic [STAGES-1:0][W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else begin
      q[0] <= src_i;
      for (int s = 1; s < STAGES; s++) q[s] <= q[s-1];
    end
  end

  assign status_o = q[STAGES-1] & ~RSVD;
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
  import lvl_irq_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned NC = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [W-1:0]          wdata_i,
  input  logic [W-1:0]          status_i,
  output logic [NC-1:0][W-1:0]  irq_msk_o,
  output logic [NC-1:0][W-1:0]  mc_msk_o,
  output logic [W-1:0]          rdata_o
);
  logic [NC-1:0] hit_irq, hit_mc;
  logic [W-1:0]  rd_mux;

  for (genvar c = 0; c < NC; c++) begin : g_core
    assign hit_irq[c] = (addr_i == OFS_IRQ_MSK + ADDR_W'(4*c));
    assign hit_mc[c]  = (addr_i == OFS_MC_MSK  + ADDR_W'(4*c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_msk_o[c] <= '0;
        mc_msk_o[c]  <= '0;
      end else if (wr_en_i) begin
        if (hit_irq[c]) irq_msk_o[c] <= wdata_i;
        if (hit_mc[c])  mc_msk_o[c]  <= wdata_i;
      end
    end

    // R9: a write that hits no mask register leaves this core's masks unchanged
    p_wr_miss_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i || !(hit_irq[c] || hit_mc[c])) |=>
        ($stable(irq_msk_o[c]) && $stable(mc_msk_o[c])));
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == OFS_STATUS) rd_mux = status_i;
    for (int c = 0; c < NC; c++) begin
      if (hit_irq[c]) rd_mux = irq_msk_o[c];
      if (hit_mc[c])  rd_mux = mc_msk_o[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  p_unmapped_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i != OFS_STATUS && !(|hit_irq) && !(|hit_mc)) |=> rdata_o == '0);
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned W  = 32,
  parameter int unsigned NC = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [W-1:0]         status_i,
  input  logic [NC-1:0][W-1:0] irq_msk_i,
  input  logic [NC-1:0][W-1:0] mc_msk_i,
  output logic [NC-1:0]        irq_o,
  output logic [NC-1:0]        mcheck_o
);
  for (genvar c = 0; c < NC; c++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irq_o[c]    <= 1'b0;
        mcheck_o[c] <= 1'b0;
      end else begin
        irq_o[c]    <= |(status_i & irq_msk_i[c]);
        mcheck_o[c] <= |(status_i & mc_msk_i[c]);
      end
    end

    p_mask_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_msk_i[c] == '0) |=> !irq_o[c]);

    p_mask_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mc_msk_i[c] == '0) |=> !mcheck_o[c]);

    p_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(status_i & irq_msk_i[c])) |=> irq_o[c]);
  end

  p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == '0) |=> (irq_o == '0 && mcheck_o == '0));

  p_both_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_i & irq_msk_i[0] & irq_msk_i[NC-1])) |=> (irq_o[0] && irq_o[NC-1]));
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import lvl_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [NUM_SRC-1:0]   wdata_i,
  output logic [NUM_SRC-1:0]   rdata_o,
  output logic [NUM_CORES-1:0] irq_o,
  output logic [NUM_CORES-1:0] mcheck_o
);
  logic [NUM_SRC-1:0]                  status;
  logic [NUM_CORES-1:0][NUM_SRC-1:0]   irq_msk, mc_msk;

  irq_sync_bank #(.W(NUM_SRC), .STAGES(SYNC_STAGES), .RSVD(RSVD_BITS)) u_sync (
    .clk_i, .rst_ni, .src_i, .status_o(status)
  );

  irq_reg_file #(.W(NUM_SRC), .NC(NUM_CORES)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .rd_en_i, .wdata_i,
    .status_i(status), .irq_msk_o(irq_msk), .mc_msk_o(mc_msk), .rdata_o
  );

  irq_out_stage #(.W(NUM_SRC), .NC(NUM_CORES)) u_out (
    .clk_i, .rst_ni, .status_i(status), .irq_msk_i(irq_msk), .mc_msk_i(mc_msk),
    .irq_o, .mcheck_o
  );

  p_rsvd_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFS_STATUS) |=> ((rdata_o & RSVD_BITS) == '0));
endmodule

// File: tb/lvl_irq_router_test.sv
module lvl_irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq, mcheck;
  int total = 0, bad = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  lvl_irq_router uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(wr_en),
    .rd_en_i(rd_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .mcheck_o(mcheck)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdr(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R8 irq", {30'd0, irq}, 32'd0);
    chk("R8 mcheck", {30'd0, mcheck}, 32'd0);
    chk("R8 rdata", rdata, 32'd0);
    for (int k = 0; k < 4; k++) begin
      rdr(8'h10 + 8'(4*k), rd);
      chk("R8 mask", rd, 32'd0);
    end
  endtask

  task automatic t_status;
    src = 32'hA5A5_5A5A; idle(2);
    rdr(8'h00, rd);
    chk("R1 status", rd, 32'hA5A5_5A5A & 32'h0001_FFBF);
    src = 32'hFFFF_FFFF; idle(2);
    rdr(8'h00, rd);
    chk("R2 reserved zero", rd, 32'h0001_FFBF);
    src = '0; idle(3);
  endtask

  task automatic t_masks;
    wr(8'h10, 32'h1111_0001);
    wr(8'h14, 32'h2222_0002);
    wr(8'h18, 32'h4444_0004);
    wr(8'h1C, 32'h8888_0008);
    rdr(8'h10, rd); chk("R3 irq0 mask", rd, 32'h1111_0001);
    rdr(8'h14, rd); chk("R3 irq1 mask", rd, 32'h2222_0002);
    rdr(8'h18, rd); chk("R3 mc0 mask", rd, 32'h4444_0004);
    rdr(8'h1C, rd); chk("R3 mc1 mask", rd, 32'h8888_0008);
    src = 32'h0000_0004; idle(3);
    chk("R5 mc0 only", {28'd0, irq, mcheck}, 32'h1);
    src = 32'h0000_0008; idle(3);
    chk("R5 mc1 only", {28'd0, irq, mcheck}, 32'h2);
    src = 32'h0000_0002; idle(3);
    chk("R4 irq1 only", {28'd0, irq, mcheck}, 32'h8);
    src = '0; idle(3);
    chk("R4 all low", {28'd0, irq, mcheck}, 32'h0);
  endtask

  task automatic t_latency;
    wr(8'h10, 32'h0000_0100);
    src = 32'h0000_0100;
    idle(2);
    chk("R11 not yet", {31'd0, irq[0]}, 32'd0);
    idle(1);
    chk("R11 third edge", {31'd0, irq[0]}, 32'd1);
    src = '0; idle(2);
    chk("R11 fall not yet", {31'd0, irq[0]}, 32'd1);
    idle(1);
    chk("R4 fall", {31'd0, irq[0]}, 32'd0);
  endtask

  task automatic t_both;
    wr(8'h10, 32'h0000_0020);
    wr(8'h14, 32'h0000_0020);
    wr(8'h18, 32'h0000_0020);
    wr(8'h1C, 32'h0000_0000);
    src = 32'h0000_0020; idle(3);
    chk("R6 shared", {28'd0, irq, mcheck}, 32'hD);
    // R2: reserved input 6 enabled everywhere drives nothing
    wr(8'h10, 32'hFFFE_0040); wr(8'h14, 32'hFFFE_0040);
    wr(8'h18, 32'hFFFE_0040); wr(8'h1C, 32'hFFFE_0040);
    src = 32'hFFFE_0040; idle(3);
    chk("R2 rsvd no drive", {28'd0, irq, mcheck}, 32'h0);
    src = '0; idle(3);
  endtask

  task automatic t_no_ack;
    wr(8'h10, 32'h0000_8000);
    src = 32'h0000_8000; idle(3);
    rdr(8'h00, rd); rdr(8'h10, rd); idle(3);
    chk("R7 held after reads", {31'd0, irq[0]}, 32'd1);
    wr(8'h10, 32'h0);
    chk("R4 mask clear lag", {31'd0, irq[0]}, 32'd1);
    idle(1);
    chk("R7 mask clear", {31'd0, irq[0]}, 32'd0);
    src = '0; idle(3);
  endtask

  task automatic t_ignored;
    wr(8'h14, 32'h1234_5678);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rdr(8'h14, rd); chk("R9 mask kept", rd, 32'h1234_5678);
    rdr(8'h10, rd); chk("R9 irq0 kept", rd, 32'h0);
    rdr(8'h00, rd); chk("R9 status unwritten", rd, 32'h0);
    rdr(8'h04, rd); chk("R9 unmapped read", rd, 32'h0);
    rdr(8'hFC, rd); chk("R9 unmapped high", rd, 32'h0);
    rdr(8'h14, rd);
    addr = 8'h00; idle(2);
    chk("R10 hold", rdata, 32'h1234_5678);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_status();
    t_masks();
    t_latency();
    t_both();
    t_no_ack();
    t_ignored();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule